// File: doc/BRIEF.md
# Nibble-Packed Bitmap Scanout with Palette

This block turns a stream of screen positions into colored pixels for a 4-bit-per-pixel bitmap stored column-major in video memory. A timing generator presents one position per cycle (x, y and a valid flag). The block forms the memory address for that position and issues a read. When the byte returns, it picks the correct 4-bit nibble, looks the nibble up in a 16-entry writable palette and expands the 8-bit palette code into 24-bit RGB.

Addresses are column-major. The line number sits in the low eight address bits, and the byte column occupies the bits above them. Each byte packs two horizontally neighbouring pixels. Palette codes hold blue in the top two bits, green in the middle three and red in the low three. Each channel is expanded with fixed non-linear weights. Because palette writes act on the very next pixels looked up, software can cycle colors without touching video memory.

The pixel stream has no back-pressure. Display timing cannot pause, so there is no ready signal. Every valid input position yields exactly one valid output pixel, with a fixed delay of two cycles. The video memory answers with a fixed latency of one cycle.

Top module: `fbscan_top`

## Requirements
- R1: For a valid position with x < 304, `mem_rd_en` is high and `mem_addr` equals {x[8:1], y[7:0]}. For any other position, or when `pix_valid` is low, `mem_rd_en` is low.
- R2: An even x takes the high nibble (bits 7:4) of the returned byte, and an odd x takes the low nibble (bits 3:0).
- R3: The palette holds 16 entries of 8 bits, all cleared by reset. A write with `pal_we` high stores `pal_data` in entry `pal_idx` at the clock edge.
- R4: A palette code is split into three fields: red is bits 2:0, green is bits 5:3 and blue is bits 7:6. For each of red and green, the 8-bit channel value is 33 times bit 0, plus 71 times bit 1, plus 151 times bit 2.
- R5: The blue channel value is 71 times code bit 6, plus 151 times code bit 7.
- R6: `rgb_valid` equals `pix_valid` delayed by exactly two cycles. The RGB of a position appears in the same cycle as its `rgb_valid`.
- R7: When a position is valid but x ≥ 304, the block still produces a valid output pixel, and its RGB is zero. When `rgb_valid` is low, RGB is also zero.
- R8: A palette write presented in the same cycle as a position is visible to that position's pixel. A write presented one cycle after the position is not visible to it.
- R9: While reset is asserted and right after it, `rgb_valid` is low and all RGB outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Position is valid this cycle |
| pix_x | input | 9 | Pixel column |
| pix_y | input | 8 | Pixel line |
| mem_rd_en | output | 1 | Video memory read request |
| mem_addr | output | 16 | Video memory byte address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | 4 | Palette entry to write |
| pal_data | input | 8 | Palette code, blue 7:6, green 5:3, red 2:0 |
| rgb_valid | output | 1 | Output pixel valid |
| rgb_r | output | 8 | Red |
| rgb_g | output | 8 | Green |
| rgb_b | output | 8 | Blue |

## Verification
Random positions that mix even and odd columns catch a swapped nibble choice or a wrong address bit. Positions at and beyond column 304, along with gaps in `pix_valid`, separate blanking from the valid-flag pipeline. Single-bit palette codes isolate each expansion weight in turn, so a wrong constant shows up in exactly one channel. Palette writes placed in the same cycle as a position, and one cycle after it, pin down when a color change takes effect.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // 3-bit channel to 8-bit intensity, non-linear weights
  function automatic logic [7:0] wexp3(input logic [2:0] c);
    return (c[0] ? 8'd33 : 8'd0) + (c[1] ? 8'd71 : 8'd0) + (c[2] ? 8'd151 : 8'd0);
  endfunction

  // 2-bit channel to 8-bit intensity
  function automatic logic [7:0] wexp2(input logic [1:0] c);
    return (c[0] ? 8'd71 : 8'd0) + (c[1] ? 8'd151 : 8'd0);
  endfunction

endpackage

// File: rtl/fbscan_addr_gen.sv
module fbscan_addr_gen #(
  parameter int X_W      = 9,
  parameter int Y_W      = 8,
  parameter int WIDTH_PX = 304,
  localparam int ADDR_W  = X_W - 1 + Y_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              nib_sel
);
  localparam logic [X_W-1:0] WIDTH_L = X_W'(WIDTH_PX);

  always_comb begin
    rd_en   = pix_valid && (pix_x < WIDTH_L);
    rd_addr = {pix_x[X_W-1:1], pix_y};
    nib_sel = pix_x[0];
  end

  // R1: a read is never requested for a column beyond the visible width
  a_r1_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (pix_valid && pix_x <= WIDTH_L - 1'b1));

endmodule

// File: rtl/fbscan_palette.sv
module fbscan_palette #(
  parameter int N_ENT  = 16,
  parameter int CODE_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [CODE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [CODE_W-1:0] rdata
);
  logic [CODE_W-1:0] tbl [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[widx] <= wdata;
    end
  end

  assign rdata = tbl[ridx];

  // R3: a write lands in the addressed entry
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ridx == widx) |=> (tbl[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/fbscan_expand.sv
module fbscan_expand
  import fbscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] code,
  output rgb_t       color
);
  logic [7:0] ch3 [2];

  for (genvar c = 0; c < 2; c++) begin : g_ch3
    assign ch3[c] = wexp3(code[3*c+2 : 3*c]);
  end

  always_comb begin
    color.r = ch3[0];
    color.g = ch3[1];
    color.b = wexp2(code[7:6]);
  end

  // R5: both blue bits give the top blue level, no blue bits give zero
  a_r5_blue_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (code[7:6] == 2'b11 |-> color.b == 8'd222) and (code[7:6] == 2'b00 |-> color.b == 8'd0));

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int X_W      = 9,
  parameter int Y_W      = 8,
  parameter int WIDTH_PX = 304,
  parameter int N_ENT    = 16,
  localparam int ADDR_W  = X_W - 1 + Y_W,
  localparam int IDX_W   = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              pal_we,
  input  logic [IDX_W-1:0]  pal_idx,
  input  logic [7:0]        pal_data,
  output logic              rgb_valid,
  output logic [7:0]        rgb_r,
  output logic [7:0]        rgb_g,
  output logic [7:0]        rgb_b
);
  logic nib_sel_c;
  logic s1_valid, s1_active, s1_nib;
  logic [IDX_W-1:0] nib;
  logic [7:0] code;
  rgb_t color, out_q;

  fbscan_addr_gen #(.X_W(X_W), .Y_W(Y_W), .WIDTH_PX(WIDTH_PX)) u_addr (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .nib_sel(nib_sel_c)
  );

  // stage 1: align position info with the one-cycle memory return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_active <= 1'b0;
      s1_nib    <= 1'b0;
    end else begin
      s1_valid  <= pix_valid;
      s1_active <= mem_rd_en;
      s1_nib    <= nib_sel_c;
    end
  end

  // even column = high nibble, odd column = low nibble
  assign nib = s1_nib ? mem_rdata[3:0] : mem_rdata[7:4];

  fbscan_palette #(.N_ENT(N_ENT), .CODE_W(8)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .widx(pal_idx), .wdata(pal_data),
    .ridx(nib), .rdata(code)
  );

  fbscan_expand u_exp (.clk(clk), .rst_n(rst_n), .code(code), .color(color));

  // stage 2: registered output, blanked outside the active area
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      out_q     <= '0;
    end else begin
      rgb_valid <= s1_valid;
      out_q     <= s1_active ? color : '0;
    end
  end

  assign rgb_r = out_q.r;
  assign rgb_g = out_q.g;
  assign rgb_b = out_q.b;

  // R6: a read request becomes a valid pixel two edges later
  a_r6_read_to_stage: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> s1_active);
  a_r6_stage_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    s1_active |=> rgb_valid);
  // R7: no color leaves the block without a valid flag
  a_r7_blank_out: assert property (@(posedge clk) disable iff (!rst_n)
    !rgb_valid |-> (rgb_r == 8'd0 && rgb_g == 8'd0 && rgb_b == 8'd0));

endmodule

// File: tb/fbscan_top_tb_top.sv
`timescale 1ns/1ps
module fbscan_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic [8:0] pix_x = '0;
  logic [7:0] pix_y = '0;
  logic mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic pal_we = 1'b0;
  logic [3:0] pal_idx = '0;
  logic [7:0] pal_data = '0;
  logic rgb_valid;
  logic [7:0] rgb_r, rgb_g, rgb_b;

  int total = 0;
  int bad = 0;
  logic [7:0] pal_m [16];
  logic [24:0] pipe0, pipe1;
  string lab0, lab1;
  int fill = 0;

  always #2.5 clk = ~clk;

  fbscan_top dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
    .rgb_valid(rgb_valid), .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_rdata <= memf(mem_addr);

  function automatic logic [7:0] e3(input logic [2:0] c);
    return (c[0] ? 8'd33 : 8'd0) + (c[1] ? 8'd71 : 8'd0) + (c[2] ? 8'd151 : 8'd0);
  endfunction
  function automatic logic [7:0] e2(input logic [1:0] c);
    return (c[0] ? 8'd71 : 8'd0) + (c[1] ? 8'd151 : 8'd0);
  endfunction

  function automatic logic [24:0] model(input logic v, input logic [8:0] x, input logic [7:0] y);
    logic [7:0] by, cd;
    logic [3:0] n;
    if (!v) return '0;
    if (x >= 9'd304) return {1'b1, 24'd0};
    by = memf({x[8:1], y});
    n  = x[0] ? by[3:0] : by[7:4];
    cd = pal_m[n];
    return {1'b1, e3(cd[2:0]), e3(cd[5:3]), e2(cd[7:6])};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check output of two drives ago, then drive new inputs
  task automatic step(input logic v, input logic [8:0] x, input logic [7:0] y,
                      input logic we, input logic [3:0] idx, input logic [7:0] d,
                      input string lab);
    logic [24:0] got;
    @(negedge clk);
    got = {rgb_valid, rgb_r, rgb_g, rgb_b};
    if (fill >= 2) chk(got == pipe1, {lab1, "/R6"}, 32'(got), 32'(pipe1));
    pipe1 = pipe0; lab1 = lab0;
    pix_valid = v; pix_x = x; pix_y = y;
    pal_we = we; pal_idx = idx; pal_data = d;
    if (we) pal_m[idx] = d;
    pipe0 = model(v, x, y); lab0 = lab;
    fill++;
    #1;
    if (v && x < 9'd304)
      chk(mem_rd_en && mem_addr == {x[8:1], y}, "R1", {15'd0, mem_rd_en, mem_addr}, {15'd0, 1'b1, x[8:1], y});
    else
      chk(!mem_rd_en, "R1", 32'(mem_rd_en), 32'd0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] wcodes [8];
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) pal_m[i] = '0;
    pipe0 = '0; pipe1 = '0; lab0 = ""; lab1 = "";
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!rgb_valid && rgb_r == 0 && rgb_g == 0 && rgb_b == 0, "R9",
        {7'd0, rgb_valid, rgb_r, rgb_g, rgb_b}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!rgb_valid && rgb_r == 0 && rgb_g == 0 && rgb_b == 0, "R9",
        {7'd0, rgb_valid, rgb_r, rgb_g, rgb_b}, 32'd0);

    // R3: reset palette gives black for every pixel
    step(1, 9'd10, 8'd20, 0, 0, 0, "R3");
    step(1, 9'd11, 8'd20, 0, 0, 0, "R3");
    // R4 / R5: single-bit codes isolate each weight
    wcodes = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80};
    for (int i = 0; i < 16; i++)
      step(0, 0, 0, 1, 4'(i), wcodes[i % 8], "R3");
    for (int k = 0; k < 8; k++)
      step(1, 9'(2 * k), 8'(k * 3), 0, 0, 0, (k < 6) ? "R4" : "R5");
    // R2: even and odd columns of the same byte
    for (int k = 0; k < 16; k++) step(0, 0, 0, 1, 4'(k), 8'(k * 17), "R3");
    step(1, 9'd100, 8'd7, 0, 0, 0, "R2");
    step(1, 9'd101, 8'd7, 0, 0, 0, "R2");
    // boundaries: last visible, first hidden, max column, invalid
    step(1, 9'd303, 8'd255, 0, 0, 0, "R2");
    step(1, 9'd0, 8'd0, 0, 0, 0, "R2");
    step(1, 9'd304, 8'd1, 0, 0, 0, "R7");
    step(1, 9'd511, 8'd255, 0, 0, 0, "R7");
    step(0, 9'd50, 8'd50, 0, 0, 0, "R7");
    // R8: write in the same cycle is seen; write one cycle later is not
    for (int k = 0; k < 16; k++) step(0, 0, 0, 1, 4'(k), 8'hFF, "R3");
    step(1, 9'd40, 8'd9, 1, memf({8'd20, 8'd9})[7:4], 8'h05, "R8");
    step(1, 9'd41, 8'd9, 0, 0, 0, "R8");
    step(0, 0, 0, 1, memf({8'd20, 8'd9})[3:0], 8'h2A, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic v, we;
      logic [8:0] x;
      v  = ($urandom % 10) != 0;
      x  = (($urandom % 8) == 0) ? 9'($urandom % 512) : 9'($urandom % 320);
      we = ($urandom % 5) == 0;
      step(v, x, 8'($urandom), we, 4'($urandom), 8'($urandom), v ? "R6" : "R7");
    end
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule